// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Protocol Checker

This block sits beside a four-bank DDR SDRAM control bus and samples the control pins on every rising clock edge. The sampled pins are clock enable for the current and previous cycle, chip select, the three command strobes (row, column, write), the two bank-select bits and address bit 10. Each cycle it turns the pin pattern into one command code. It also reports the bank the command targets, whether a read or write asks for auto-precharge, and whether a precharge covers every bank.

The block keeps a small model of each bank: open or closed, an auto-precharge burst in flight, and the precharge recovery time after that burst. It uses this model to spot protocol mistakes by the controller that drives the bus. These mistakes are:
- a mode-register write or refresh while a row is open;
- a command issued too soon after a mode-register write;
- an access that cuts into a write burst with auto-precharge;
- an activate that comes before the recovery time after an auto-precharge;
- an access to a closed bank, or an activate to an open bank.

Each kind of violation sets its own bit in a sticky error vector. A synchronous clear input resets that vector.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high in both cycles, the pins {cs_n,ras_n,cas_n,we_n} decode to cmd_code as follows: 0000 gives 1 (mode set), 0001 gives 2 (auto refresh), 0011 gives 5 (activate), 0101 gives 6 (read), 0100 gives 7 (write), 0110 gives 8 (burst stop) and 0010 gives 9 (precharge). The pattern 0111, or cs_n high, gives 0 (no command).
- R2: cmd_bank equals {ba[1],ba[0]} for activate, read, write and single-bank precharge, and 0 otherwise. cmd_autopre equals a10 for read and write, and 0 otherwise. cmd_pre_all equals a10 for precharge, and 0 otherwise.
- R3: All outputs are registered. The decode of the pins sampled at one rising edge appears after that edge. While rst_n is low, all outputs are 0.
- R4: When cke_prev is high and cke is low, the refresh pattern decodes to 3 (self-refresh entry), the pattern 0111 or cs_n high decodes to 10 (power-down entry), and any other pattern decodes to 0. When cke_prev is low, cke high decodes to 4 (exit) and cke low decodes to 0. A command that decodes to 0 changes no bank state.
- R5: err_flags bit 0 is set by a mode set, an auto refresh or a self-refresh entry while any bank is open.
- R6: err_flags bit 1 is set by any nonzero command code in the two cycles that follow a mode set.
- R7: err_flags bit 3 is set by a read or write to a closed bank, or by an activate to an open bank. An activate opens a bank. A precharge closes the addressed bank, or all banks when a10 is high. An auto-precharge burst closes its bank when the burst ends.
- R8: A read or write with a10 high starts a burst of BURST_LEN cycles. Any read or write in the BURST_LEN cycles after a write with auto-precharge sets err_flags bit 2. A read with auto-precharge blocks nothing.
- R9: After an auto-precharge burst ends, an activate to that bank sets err_flags bit 2 until T_RP cycles have passed. The first legal activate comes BURST_LEN+T_RP+1 cycles after the read or write.
- R10: A burst stop never sets an error bit. It ends every auto-precharge burst at once, closes those banks and starts their T_RP recovery.
- R11: err_flags bits stay set until err_clr is high at a clock edge. That edge clears the vector, and errors from the same edge are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of the error vector |
| cke_prev | input | 1 | Clock enable as sampled in the previous cycle |
| cke | input | 1 | Clock enable in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select bits |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Target bank of the command |
| cmd_autopre | output | 1 | Read/write requests auto-precharge |
| cmd_pre_all | output | 1 | Precharge covers all banks |
| err_flags | output | 4 | Sticky violation bits (0 idle, 1 lockout, 2 burst, 3 bank state) |

## Verification
A wrong open/closed bit in the bank model cannot be seen at once. It shows up only at the next access to that bank, when bit 3 is set where it should not be or stays clear where it should be set. The stimulus therefore always follows a state change with an access that exposes it. A burst or recovery counter that is off by one moves the edge of the error window by one cycle. The bench probes both sides of every window: the last cycle that is flagged and the first cycle that is not. An error in the lockout counter shows up within three cycles after a mode set.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_MODE    = 4'd1,
    CMD_AREF    = 4'd2,
    CMD_SREF_IN = 4'd3,
    CMD_WAKE    = 4'd4,
    CMD_OPEN    = 4'd5,
    CMD_READ    = 4'd6,
    CMD_WRITE   = 4'd7,
    CMD_HALT    = 4'd8,
    CMD_CLOSE   = 4'd9,
    CMD_PDN_IN  = 4'd10
  } cmd_e;

  localparam int ERR_W        = 4;
  localparam int ERR_NOT_IDLE = 0;
  localparam int ERR_LOCKOUT  = 1;
  localparam int ERR_BURST    = 2;
  localparam int ERR_BANK     = 3;

  // Pin pattern to command, including clock-enable transitions.
  function automatic cmd_e decode_pins(input logic cke_p, input logic cke_c,
                                       input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    logic [2:0] s;
    s = {ras_n, cas_n, we_n};
    if (!cke_p) return cke_c ? CMD_WAKE : CMD_NONE;
    if (!cke_c) begin
      if (!cs_n && s == 3'b001) return CMD_SREF_IN;
      if (cs_n || s == 3'b111) return CMD_PDN_IN;
      return CMD_NONE;
    end
    if (cs_n) return CMD_NONE;
    case (s)
      3'b000:  return CMD_MODE;
      3'b001:  return CMD_AREF;
      3'b011:  return CMD_OPEN;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b110:  return CMD_HALT;
      3'b010:  return CMD_CLOSE;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction

  function automatic logic wants_idle(input cmd_e c);
    return (c == CMD_MODE) || (c == CMD_AREF) || (c == CMD_SREF_IN);
  endfunction

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
  import sdcm_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_prev,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output cmd_e            cmd,
  output logic [BA_W-1:0] bank,
  output logic            autopre,
  output logic            pre_all
);
  logic uses_bank;

  always_comb begin
    cmd       = decode_pins(cke_prev, cke, cs_n, ras_n, cas_n, we_n);
    uses_bank = (cmd == CMD_OPEN) || is_access(cmd) || (cmd == CMD_CLOSE && !a10);
    bank      = uses_bank ? ba : '0;
    autopre   = is_access(cmd) && a10;
    pre_all   = (cmd == CMD_CLOSE) && a10;
  end
endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank #(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rwap_i,
  input  logic wr_i,
  input  logic pre_i,
  input  logic halt_i,
  output logic open_o,
  output logic wr_burst_o,
  output logic busy_o
);
  localparam int BW = $clog2(BURST_LEN + 1);
  localparam int RW = $clog2(T_RP + 2);

  logic [BW-1:0] bcnt;
  logic [RW-1:0] rcnt;
  logic          wr_q;
  logic          burst_end;

  assign burst_end  = (bcnt == BW'(1)) || (halt_i && bcnt != '0);
  assign wr_burst_o = (bcnt != '0) && wr_q;
  assign busy_o     = (bcnt != '0) || (rcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      bcnt   <= '0;
      rcnt   <= '0;
      wr_q   <= 1'b0;
    end else begin
      if (rcnt != '0) rcnt <= rcnt - 1'b1;
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (halt_i)     bcnt <= '0;
      if (burst_end) begin
        rcnt   <= RW'(T_RP);
        open_o <= 1'b0;
      end
      if (act_i) open_o <= 1'b1;
      if (pre_i) open_o <= 1'b0;
      if (rwap_i) begin
        bcnt <= BW'(BURST_LEN);
        wr_q <= wr_i;
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import sdcm_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int MODE_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clr,
  input  logic             cke_prev,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic [3:0]       cmd_code,
  output logic [BA_W-1:0]  cmd_bank,
  output logic             cmd_autopre,
  output logic             cmd_pre_all,
  output logic [ERR_W-1:0] err_flags
);
  localparam int NB = 1 << BA_W;
  localparam int GW = $clog2(MODE_GAP + 1);

  cmd_e            cmd_now;
  logic [BA_W-1:0] bank_now;
  logic            ap_now;
  logic            pall_now;

  sdcm_decode #(.BA_W(BA_W)) u_decode (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .a10      (a10),
    .cmd      (cmd_now),
    .bank     (bank_now),
    .autopre  (ap_now),
    .pre_all  (pall_now)
  );

  logic [NB-1:0] bank_open;
  logic [NB-1:0] bank_busy;
  logic [NB-1:0] bank_wrb;
  logic          halt_now;

  assign halt_now = (cmd_now == CMD_HALT);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit_i;
    assign hit_i = (ba == BA_W'(i));
    sdcm_bank #(.BURST_LEN(BURST_LEN), .T_RP(T_RP)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (cmd_now == CMD_OPEN && hit_i),
      .rwap_i     (ap_now && hit_i),
      .wr_i       (cmd_now == CMD_WRITE),
      .pre_i      (cmd_now == CMD_CLOSE && (pall_now || hit_i)),
      .halt_i     (halt_now),
      .open_o     (bank_open[i]),
      .wr_burst_o (bank_wrb[i]),
      .busy_o     (bank_busy[i])
    );
  end

  // Events brought out for the checker.
  logic           needs_idle;
  logic           all_idle;
  logic           lock_active;
  logic           tgt_open;
  logic           tgt_busy;
  logic [GW-1:0]  gap_cnt;
  logic [ERR_W-1:0] err_hit;

  assign needs_idle  = wants_idle(cmd_now);
  assign all_idle    = (bank_open == '0);
  assign lock_active = (gap_cnt != '0);
  assign tgt_open    = bank_open[ba];
  assign tgt_busy    = bank_busy[ba];

  always_comb begin
    err_hit               = '0;
    err_hit[ERR_NOT_IDLE] = needs_idle && !all_idle;
    err_hit[ERR_LOCKOUT]  = lock_active && (cmd_now != CMD_NONE);
    err_hit[ERR_BURST]    = (is_access(cmd_now) && (bank_wrb != '0)) ||
                            (cmd_now == CMD_OPEN && tgt_busy);
    err_hit[ERR_BANK]     = (is_access(cmd_now) && !tgt_open) ||
                            (cmd_now == CMD_OPEN && tgt_open);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt     <= '0;
      cmd_code    <= '0;
      cmd_bank    <= '0;
      cmd_autopre <= 1'b0;
      cmd_pre_all <= 1'b0;
      err_flags   <= '0;
    end else begin
      if (cmd_now == CMD_MODE)  gap_cnt <= GW'(MODE_GAP);
      else if (lock_active)     gap_cnt <= gap_cnt - 1'b1;
      cmd_code    <= cmd_now;
      cmd_bank    <= bank_now;
      cmd_autopre <= ap_now;
      cmd_pre_all <= pall_now;
      err_flags   <= err_clr ? '0 : (err_flags | err_hit);
    end
  end
endmodule

module ddr_cmd_monitor_sva #(
  parameter int BA_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_clr,
  input logic              cke_prev,
  input logic              needs_idle,
  input logic [(1<<BA_W)-1:0] bank_open,
  input logic [3:0]        cmd_code,
  input logic              cmd_pre_all,
  input logic [3:0]        err_flags
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R11
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_flags == 4'd0)); // R11
  AST_IDLE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (needs_idle && bank_open != '0 && !err_clr) |=> err_flags[0]); // R5
  AST_MODE_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != 4'd0 && $past(cmd_code) == 4'd1 && !$past(err_clr)) |-> err_flags[1]); // R6
  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_prev |=> (cmd_code == 4'd0 || cmd_code == 4'd4)); // R4
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd9 && cmd_pre_all) |-> (bank_open == '0)); // R7
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_sva #(.BA_W(BA_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_clr     (err_clr),
  .cke_prev    (cke_prev),
  .needs_idle  (needs_idle),
  .bank_open   (bank_open),
  .cmd_code    (cmd_code),
  .cmd_pre_all (cmd_pre_all),
  .err_flags   (err_flags)
);

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] P_MODE = 4'b0000, P_REF = 4'b0001, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_BST = 4'b0110,
                         P_PRE = 4'b0010, P_NOP = 4'b0111, P_DES = 4'b1111;

  typedef struct {
    int         code;
    logic [1:0] bank;
    logic       ap;
    logic       pall;
    logic [3:0] err;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_clr = 1'b0;
  logic cke_prev = 1'b1, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic cmd_autopre, cmd_pre_all;
  logic [3:0] err_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t q[$];
  logic [3:0] exp_err = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .cke_prev(cke_prev), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre),
    .cmd_pre_all(cmd_pre_all), .err_flags(err_flags)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (cmd_code != 4'(e.code) || cmd_bank != e.bank || cmd_autopre != e.ap ||
        cmd_pre_all != e.pall || err_flags != e.err) begin
      errors++;
      $display("FAIL %s: got code=%0d bank=%0d ap=%0b pall=%0b err=%b, expected code=%0d bank=%0d ap=%0b pall=%0b err=%b",
               e.req, cmd_code, cmd_bank, cmd_autopre, cmd_pre_all, err_flags,
               e.code, e.bank, e.ap, e.pall, e.err);
    end
  endtask

  // Driver: one command per cycle, expectation pushed to the scoreboard.
  task automatic step(input logic cp, input logic ck, input logic [3:0] pins,
                      input logic [1:0] b, input logic a, input logic clr,
                      input int code, input logic [3:0] new_err, input string req);
    exp_t e;
    @(negedge clk);
    cke_prev = cp; cke = ck;
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b; a10 = a; err_clr = clr;
    exp_err = clr ? 4'b0 : (exp_err | new_err);
    e.code = code;
    e.bank = (code == 5 || code == 6 || code == 7 || (code == 9 && !a)) ? b : 2'd0;
    e.ap   = (code == 6 || code == 7) ? a : 1'b0;
    e.pall = (code == 9) ? a : 1'b0;
    e.err  = exp_err;
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [3:0] pins, input logic [1:0] b, input logic a,
                     input int code, input logic [3:0] new_err, input string req);
    step(1'b1, 1'b1, pins, b, a, 1'b0, code, new_err, req);
  endtask

  task automatic clear(input string req);
    step(1'b1, 1'b1, P_NOP, 2'd0, 1'b0, 1'b1, 0, 4'b0, req);
  endtask

  // Monitor: pops one expectation per edge after the sampling edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r = '{code: 0, bank: 2'd0, ap: 1'b0, pall: 1'b0, err: 4'b0, req: "R3 reset"};
    compare(r);
    @(negedge clk); rst_n = 1'b1;

    cmd(P_MODE, 0, 0, 1, 4'b0000, "R1 mode set");
    cmd(P_NOP,  0, 0, 0, 4'b0000, "R6 nop in gap");
    cmd(P_DES,  0, 0, 0, 4'b0000, "R1 deselect");
    cmd(P_ACT,  1, 0, 5, 4'b0000, "R6 after gap");
    cmd(P_MODE, 0, 0, 1, 4'b0001, "R5 mode with open bank");
    cmd(P_ACT,  2, 0, 5, 4'b0010, "R6 lockout");
    clear("R11 clear");
    cmd(P_RD,   1, 0, 6, 4'b0000, "R2 read open bank");
    cmd(P_RD,   0, 0, 6, 4'b1000, "R7 read closed");
    clear("R11 clear");
    cmd(P_ACT,  1, 0, 5, 4'b1000, "R7 act open");
    clear("R11 clear");
    // write with auto-precharge on bank 1
    cmd(P_WR,   1, 1, 7, 4'b0000, "R2 write ap");
    cmd(P_RD,   2, 0, 6, 4'b0100, "R8 read in wr burst");
    clear("R11 clear");
    cmd(P_NOP,  0, 0, 0, 4'b0000, "R8 nop");
    cmd(P_NOP,  0, 0, 0, 4'b0000, "R8 last burst cycle");
    cmd(P_RD,   2, 0, 6, 4'b0000, "R8 read after burst");
    cmd(P_RD,   1, 0, 6, 4'b1000, "R7 closed by ap");
    clear("R11 clear");
    cmd(P_ACT,  1, 0, 5, 4'b0000, "R9 first legal act");
    // read with auto-precharge on bank 1
    cmd(P_RD,   1, 1, 6, 4'b0000, "R2 read ap");
    cmd(P_RD,   2, 0, 6, 4'b0000, "R8 read ap no block");
    for (int i = 0; i < 4; i++) cmd(P_NOP, 0, 0, 0, 4'b0000, "R9 wait");
    cmd(P_ACT,  1, 0, 5, 4'b0100, "R9 act in trp");
    clear("R11 clear");
    // burst stop
    cmd(P_WR,   1, 1, 7, 4'b0000, "R10 write ap");
    cmd(P_BST,  0, 0, 8, 4'b0000, "R10 burst stop");
    cmd(P_RD,   2, 0, 6, 4'b0000, "R10 burst ended");
    cmd(P_RD,   1, 0, 6, 4'b1000, "R10 bank closed");
    cmd(P_ACT,  1, 0, 5, 4'b0100, "R10 trp after stop");
    clear("R11 clear");
    // precharge forms
    cmd(P_PRE,  3, 1, 9, 4'b0000, "R2 precharge all");
    cmd(P_REF,  0, 0, 2, 4'b0000, "R5 refresh idle");
    cmd(P_ACT,  0, 0, 5, 4'b0000, "R7 open bank0");
    cmd(P_PRE,  3, 0, 9, 4'b0000, "R7 precharge bank3");
    cmd(P_REF,  0, 0, 2, 4'b0001, "R5 refresh open");
    clear("R11 clear");
    cmd(P_PRE,  0, 0, 9, 4'b0000, "R7 precharge bank0");
    cmd(P_REF,  0, 0, 2, 4'b0000, "R5 refresh idle again");
    // clock-enable transitions
    step(1, 0, P_REF,  0, 0, 0, 3,  4'b0000, "R4 self refresh entry");
    step(0, 0, P_ACT,  1, 0, 0, 0,  4'b0000, "R4 ignored while low");
    step(0, 1, P_NOP,  0, 0, 0, 4,  4'b0000, "R4 exit");
    step(1, 0, P_DES,  0, 0, 0, 10, 4'b0000, "R4 power down entry");
    step(0, 0, P_MODE, 0, 0, 0, 0,  4'b0000, "R4 mode ignored low");
    step(0, 1, P_DES,  0, 0, 0, 4,  4'b0000, "R4 exit");
    step(1, 0, P_ACT,  1, 0, 0, 0,  4'b0000, "R4 other on falling");
    cmd(P_ACT,  1, 0, 5, 4'b0000, "R4 no state change");
    step(1, 0, P_REF,  0, 0, 0, 3,  4'b0001, "R5 self refresh open");
    clear("R11 clear");
    cmd(P_NOP,  0, 0, 0, 4'b0000, "R1 nop");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3: got %0d pending, expected 0", q.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule